// File: doc/BRIEF.md
# Big-Endian Load/Store Alignment Unit

This unit sits between a 32-bit integer datapath and a word-wide synchronous data RAM. Each request carries a base register value, a signed 16-bit displacement, an access width (byte, halfword or word) and a direction. The unit adds the two address operands and forces the result onto the natural boundary of the access width. It then presents a word address to the RAM in the same cycle. Misaligned addresses are masked, never trapped.

For a store, the low byte, low halfword or full word of the source register is steered onto the byte lanes that the address selects, and one write strobe per lane is raised. Lanes that are not selected keep their RAM contents. For a load, the RAM returns its word one cycle after the request. The unit picks the addressed byte or halfword from that word in big-endian order, where the lowest address holds the most significant byte. It then sign- or zero-extends the value to 32 bits.

Top module: `be_lsu_align`

## Requirements
- R1: The effective address is `req_base` plus `req_offset` sign-extended to 32 bits. In the cycle `req_valid` is high, `mem_en` is high and `mem_addr` carries bits 31:2 of the aligned effective address.
- R2: For a halfword access (`req_size` = 2'b01), address bit 0 is forced to zero before the word address and lane are chosen.
- R3: For a word access (`req_size` = 2'b10, and the code 2'b11, which behaves the same), address bits 1:0 are forced to zero. A word store raises all four strobes, with the source word unchanged on `mem_wdata`.
- R4: A byte store (`req_size` = 2'b00) raises exactly one strobe. Byte offset k within the word drives `mem_be[3-k]`, and lane k is `mem_wdata[31-8k:24-8k]`. The source low byte appears on every lane, and the other three RAM bytes keep their values.
- R5: A halfword store raises `mem_be` = 4'b1100 when address bit 1 is 0, or 4'b0011 when it is 1. The source low halfword appears on both halves of `mem_wdata`.
- R6: A load raises neither `mem_we` nor any bit of `mem_be`.
- R7: `load_valid` is high in the cycle after each load request, and only then. `load_data` is valid in that cycle. Back-to-back loads produce back-to-back results.
- R8: A byte load with `req_zext` = 0 sign-extends the addressed byte, so 0xFF reads as 0xFFFFFFFF. With `req_zext` = 1 it zero-extends, so 0xFF reads as 0x000000FF. The byte at offset k is taken from `mem_rdata[31-8k:24-8k]`.
- R9: A halfword load takes `mem_rdata[31:16]` when address bit 1 is 0, or `mem_rdata[15:0]` when it is 1. The value is sign- or zero-extended as selected by `req_zext`.
- R10: A word load returns all 32 bits of the RAM word unchanged, whatever the value of `req_zext`.
- R11: While reset is applied, and until the internal synchronized release, `load_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_zext | input | 1 | Narrow loads: 1 zero-extend, 0 sign-extend |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_wdata | input | 32 | Store source register |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write |
| mem_addr | output | 30 | RAM word address |
| mem_wdata | output | 32 | Lane-steered write data |
| mem_be | output | 4 | Per-lane write strobes, bit 3 = bits 31:24 |
| mem_rdata | input | 32 | RAM read word, one cycle after the request |
| load_valid | output | 1 | Load result valid |
| load_data | output | 32 | Extended load result |

## Verification
The assertions assume that the RAM returns the word of a read request on the cycle after it, and that `req_size`, `req_zext` and `req_store` are stable and known while `req_valid` is high. The bench drives every request for exactly one cycle, at the falling edge. It pairs the unit with a RAM model that has exactly one cycle of read latency and writes only the strobed lanes. Every access reaches its RAM word only through the unit's own ports. Misaligned and negative-displacement addresses are included deliberately, because masking them is part of the defined behaviour.

// File: rtl/lane_pkg.sv
package lane_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } acc_size_e;
endpackage

// File: rtl/lsu_rst_sync.sv
module lsu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen import lane_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int OFF_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    valid,
  input  acc_size_e               size,
  input  logic [ADDR_W-1:0]       base,
  input  logic [IMM_W-1:0]        imm,
  output logic [ADDR_W-OFF_W-1:0] word_addr,
  output logic [OFF_W-1:0]        lane
);
  logic [ADDR_W-1:0] ea;
  logic [ADDR_W-1:0] ea_al;

  // sum of base and sign-extended displacement, then forced alignment
  always_comb begin
    ea    = base + {{(ADDR_W-IMM_W){imm[IMM_W-1]}}, imm};
    ea_al = ea;
    case (size)
      SZ_BYTE: ea_al = ea;
      SZ_HALF: ea_al[0] = 1'b0;
      default: ea_al[OFF_W-1:0] = '0;
    endcase
  end

  assign word_addr = ea_al[ADDR_W-1:OFF_W];
  assign lane      = ea_al[OFF_W-1:0];

  // R2: halfword lanes are always even
  p_half_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && size == SZ_HALF) |-> (lane[0] == 1'b0));

  // R3: word accesses always start at lane 0
  p_word_lane0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && (size == SZ_WORD || size == SZ_WIDE)) |-> (lane == '0));
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes import lane_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int OFF_W  = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  acc_size_e         size,
  input  logic [OFF_W-1:0]  lane,
  input  logic [DATA_W-1:0] src,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] wdata
);
  // lane i occupies bits DATA_W-1-8i downto DATA_W-8-8i (big-endian)
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int HI = DATA_W - 1 - 8 * i;
    logic       hit_byte;
    logic       hit_half;
    logic [7:0] half_src;

    assign hit_byte = (lane == OFF_W'(i));
    assign hit_half = (lane[OFF_W-1:1] == (OFF_W-1)'(i / 2));

    if ((i % 2) == 0) begin : g_even
      assign half_src = src[15:8];
    end else begin : g_odd
      assign half_src = src[7:0];
    end

    assign be[LANES-1-i] = (size == SZ_BYTE) ? hit_byte :
                           (size == SZ_HALF) ? hit_half : 1'b1;

    assign wdata[HI -: 8] = (size == SZ_BYTE) ? src[7:0] :
                            (size == SZ_HALF) ? half_src : src[HI -: 8];
  end

  // R4: a byte store touches exactly one lane
  p_byte_one_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && size == SZ_BYTE) |-> ($countones(be) == 1));

  // R5: a halfword store touches exactly two lanes
  p_half_two_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && size == SZ_HALF) |-> ($countones(be) == 2));

  // R3: a word store touches every lane
  p_word_all_lanes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && (size == SZ_WORD || size == SZ_WIDE)) |-> (&be));
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract import lane_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int OFF_W  = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  acc_size_e         size,
  input  logic              zext,
  input  logic [OFF_W-1:0]  lane,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] data
);
  localparam int HALVES = LANES / 2;

  logic [7:0]  lane_b [LANES];
  logic [15:0] pair_h [HALVES];
  logic [7:0]  pick_b;
  logic [15:0] pick_h;

  for (genvar i = 0; i < LANES; i++) begin : g_bytes
    assign lane_b[i] = rdata[DATA_W-1-8*i -: 8];
  end

  for (genvar j = 0; j < HALVES; j++) begin : g_pairs
    assign pair_h[j] = {lane_b[2*j], lane_b[2*j+1]};
  end

  always_comb begin
    pick_b = lane_b[lane];
    pick_h = pair_h[lane[OFF_W-1:1]];
    case (size)
      SZ_BYTE: data = zext ? {{(DATA_W-8){1'b0}}, pick_b}
                           : {{(DATA_W-8){pick_b[7]}}, pick_b};
      SZ_HALF: data = zext ? {{(DATA_W-16){1'b0}}, pick_h}
                           : {{(DATA_W-16){pick_h[15]}}, pick_h};
      default: data = rdata;
    endcase
  end

  // R8: zero-extended byte has a clear upper part
  p_zext_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && zext && size == SZ_BYTE) |-> (data[DATA_W-1:8] == '0));

  // R8: sign-extended byte has a uniform upper part
  p_sext_byte_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !zext && size == SZ_BYTE) |->
      ((data[DATA_W-1:7] == '0) || (&data[DATA_W-1:7])));

  // R9: sign-extended halfword has a uniform upper part
  p_sext_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !zext && size == SZ_HALF) |->
      ((data[DATA_W-1:15] == '0) || (&data[DATA_W-1:15])));
endmodule

// File: rtl/be_lsu_align.sv
module be_lsu_align import lane_pkg::*; #(
  parameter  int DATA_W = 32,
  parameter  int IMM_W  = 16,
  localparam int LANES  = DATA_W / 8,
  localparam int OFF_W  = $clog2(LANES),
  localparam int WA_W   = DATA_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic              req_zext,
  input  logic [DATA_W-1:0] req_base,
  input  logic [IMM_W-1:0]  req_offset,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [WA_W-1:0]   mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [LANES-1:0]  mem_be,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              load_valid,
  output logic [DATA_W-1:0] load_data
);
  logic             rst_q_n;
  acc_size_e        size_in;
  logic [OFF_W-1:0] lane_in;
  logic [LANES-1:0] lane_be;

  // load-side control captured at the request edge
  logic             ld_v_d,    ld_v_q;
  logic             ctl_en;
  acc_size_e        size_d,    size_q;
  logic             zext_d,    zext_q;
  logic [OFF_W-1:0] lane_d,    lane_q;

  assign size_in = acc_size_e'(req_size);

  lsu_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_q_n)
  );

  lsu_addr_gen #(.ADDR_W(DATA_W), .IMM_W(IMM_W), .OFF_W(OFF_W)) u_addr_gen (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .valid     (req_valid),
    .size      (size_in),
    .base      (req_base),
    .imm       (req_offset),
    .word_addr (mem_addr),
    .lane      (lane_in)
  );

  lsu_store_lanes #(.DATA_W(DATA_W)) u_store_lanes (
    .clk   (clk),
    .rst_n (rst_q_n),
    .valid (req_valid && req_store),
    .size  (size_in),
    .lane  (lane_in),
    .src   (req_wdata),
    .be    (lane_be),
    .wdata (mem_wdata)
  );

  assign mem_en = req_valid;
  assign mem_we = req_valid && req_store;
  assign mem_be = lane_be & {LANES{mem_we}};

  // next-state
  always_comb begin
    ld_v_d = req_valid && !req_store;
    ctl_en = ld_v_d;
    size_d = size_in;
    zext_d = req_zext;
    lane_d = lane_in;
  end

  // registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      ld_v_q <= 1'b0;
      size_q <= SZ_WORD;
      zext_q <= 1'b0;
      lane_q <= '0;
    end else begin
      ld_v_q <= ld_v_d;
      if (ctl_en) begin
        size_q <= size_d;
        zext_q <= zext_d;
        lane_q <= lane_d;
      end
    end
  end

  lsu_load_extract #(.DATA_W(DATA_W)) u_load_extract (
    .clk   (clk),
    .rst_n (rst_q_n),
    .valid (ld_v_q),
    .size  (size_q),
    .zext  (zext_q),
    .lane  (lane_q),
    .rdata (mem_rdata),
    .data  (load_data)
  );

  assign load_valid = ld_v_q;

  // R6: loads never write
  p_load_no_write_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid && !req_store) |-> (!mem_we && mem_be == '0));

  // R7: a load request yields a result on the next cycle
  p_load_result_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (req_valid && !req_store) |=> load_valid);

  // R7: no result without a load request the cycle before
  p_no_stray_result_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(req_valid && !req_store) |=> !load_valid);
endmodule

// File: tb/be_lsu_align_bench.sv
`timescale 1ns/1ps
module be_lsu_align_bench;
  logic        clk;
  logic        rst_n;
  logic        req_valid, req_store, req_zext;
  logic [1:0]  req_size;
  logic [31:0] req_base, req_wdata;
  logic [15:0] req_offset;
  logic        mem_en, mem_we;
  logic [29:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        load_valid;
  logic [31:0] load_data;

  int compared   = 0;
  int mismatched = 0;
  bit done       = 0;

  logic [31:0] ram     [16];
  logic [31:0] ref_mem [16];
  logic [31:0] exp_q   [$];
  string       tag_q   [$];

  be_lsu_align u_be_lsu_align (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_zext(req_zext), .req_base(req_base),
    .req_offset(req_offset), .req_wdata(req_wdata), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_be(mem_be), .mem_rdata(mem_rdata), .load_valid(load_valid),
    .load_data(load_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // synchronous RAM model, one cycle read latency, strobed writes
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) ram[mem_addr[3:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= ram[mem_addr[3:0]];
      end
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected load results
  always @(negedge clk) begin
    if (rst_n && load_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        check("R7 stray load_valid", 32'd1, 32'd0);
      end else begin
        check(tag_q.pop_front(), load_data, exp_q.pop_front());
      end
    end
  end

  function automatic logic [31:0] align(logic [1:0] sz, logic [31:0] base,
                                        logic [15:0] off);
    logic [31:0] ea;
    ea = base + {{16{off[15]}}, off};
    if (sz == 2'b01)      ea[0]   = 1'b0;
    else if (sz != 2'b00) ea[1:0] = 2'b00;
    return ea;
  endfunction

  task automatic issue(bit st, logic [1:0] sz, bit zx, logic [31:0] base,
                       logic [15:0] off, logic [31:0] d, string tag);
    logic [31:0] a, w, e, ewd;
    logic [3:0]  ebe;
    logic [7:0]  b8;
    logic [15:0] h16;
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_size = sz; req_zext = zx;
    req_base = base; req_offset = off; req_wdata = d;
    a = align(sz, base, off);
    #1;
    check({tag, " mem_en"}, {31'd0, mem_en}, 32'd1);
    check({tag, " mem_addr"}, {2'b00, mem_addr}, {2'b00, a[31:2]});
    w = ref_mem[a[5:2]];
    if (st) begin
      if (sz == 2'b00) begin
        ebe = 4'b1000 >> a[1:0]; ewd = {4{d[7:0]}};
      end else if (sz == 2'b01) begin
        ebe = a[1] ? 4'b0011 : 4'b1100; ewd = {2{d[15:0]}};
      end else begin
        ebe = 4'b1111; ewd = d;
      end
      check({tag, " mem_we"}, {31'd0, mem_we}, 32'd1);
      check({tag, " mem_be"}, {28'd0, mem_be}, {28'd0, ebe});
      check({tag, " mem_wdata"}, mem_wdata, ewd);
      for (int b = 0; b < 4; b++) if (ebe[b]) w[8*b +: 8] = ewd[8*b +: 8];
      ref_mem[a[5:2]] = w;
    end else begin
      check("R6 load mem_we/mem_be", {27'd0, mem_we, mem_be}, 32'd0);
      b8  = w[31 - 8*a[1:0] -: 8];
      h16 = a[1] ? w[15:0] : w[31:16];
      if (sz == 2'b00)      e = zx ? {24'd0, b8}  : {{24{b8[7]}}, b8};
      else if (sz == 2'b01) e = zx ? {16'd0, h16} : {{16{h16[15]}}, h16};
      else                  e = w;
      exp_q.push_back(e);
      tag_q.push_back({tag, " load_data"});
    end
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; req_store = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_store = 1'b0; req_size = 2'b00;
    req_zext = 1'b0; req_base = '0; req_offset = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 load_valid in reset", {31'd0, load_valid}, 32'd0);
    check("R1 mem_en idle", {31'd0, mem_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 load_valid before sync release", {31'd0, load_valid}, 32'd0);
    repeat (3) @(negedge clk);

    // R3: word stores, one through a misaligned base
    issue(1, 2'b10, 0, 32'h0,  16'h0, 32'h11223344, "R3 sw 0x0");
    issue(1, 2'b10, 0, 32'h4,  16'h0, 32'h55667788, "R3 sw 0x4");
    issue(1, 2'b10, 0, 32'h8,  16'h0, 32'h99AABBCC, "R3 sw 0x8");
    issue(1, 2'b10, 0, 32'hC,  16'h0, 32'hDDEEF00D, "R3 sw 0xC");
    issue(1, 2'b10, 0, 32'h13, 16'h0, 32'hCAFEBABE, "R3 sw masked 0x13");
    idle();
    check("R7 no result after stores", {31'd0, load_valid}, 32'd0);

    // R4: byte store base 9 + 5 -> 0xE, lane 2
    issue(1, 2'b00, 0, 32'h9, 16'h5, 32'h000000FF, "R4 sb 0xE");
    // R4/R10: neighbours preserved, word read back
    issue(0, 2'b10, 0, 32'hC, 16'h0, 32'h0, "R10 lw 0xC after sb");
    // R8: signed/unsigned byte loads
    issue(0, 2'b00, 0, 32'h9, 16'h5, 32'h0, "R8 lb 0xE");
    issue(0, 2'b00, 1, 32'h9, 16'h5, 32'h0, "R8 lbu 0xE");
    issue(0, 2'b00, 0, 32'h0, 16'h0, 32'h0, "R8 lb positive 0x0");
    issue(0, 2'b00, 0, 32'h8, 16'h1, 32'h0, "R8 lb lane1 0x9");
    issue(0, 2'b00, 1, 32'h8, 16'h3, 32'h0, "R8 lbu lane3 0xB");
    // R1: negative displacement
    issue(0, 2'b10, 0, 32'h20, 16'hFFE4, 32'h0, "R1 lw 0x20-28");
    idle();

    // R2/R5: halfword stores
    issue(1, 2'b01, 0, 32'h11, 16'h0, 32'h00008001, "R5 sh odd 0x11");
    issue(1, 2'b01, 0, 32'h10, 16'h2, 32'hFFFF1234, "R5 sh 0x12");
    // R9: halfword loads
    issue(0, 2'b01, 0, 32'h11, 16'h0, 32'h0, "R9 lh 0x10");
    issue(0, 2'b01, 1, 32'h11, 16'h0, 32'h0, "R9 lhu 0x10");
    issue(0, 2'b01, 0, 32'h13, 16'h0, 32'h0, "R2 lh masked 0x13");
    issue(0, 2'b10, 1, 32'h10, 16'h0, 32'h0, "R10 lw 0x10 zext ignored");
    // R3: misaligned word load and code 2'b11
    issue(0, 2'b10, 0, 32'h7, 16'h0, 32'h0, "R3 lw masked 0x7");
    issue(0, 2'b11, 0, 32'h2, 16'h0, 32'h0, "R3 size code 3 0x2");
    idle();
    repeat (3) @(negedge clk);

    check("R7 all results seen", exp_q.size(), 32'd0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule